// File: doc/BRIEF.md
# Fixed-Frequency Current Chopping Controller

This block decides, cycle by cycle, whether one H-bridge drives its winding as the host requests or shorts it in slow decay. A free-running counter sets a fixed chopping period (nominally 50 kHz, given in clock cycles). Drive is always enabled at the start of each period. For a blanking window after that point the current-sense comparator is ignored. This window also sets the minimum on-time. Once blanking ends, a comparator trip latches slow decay, with both low-side switches on, until the next period starts.

The block sits between the host's direction inputs and the gate predrive. It produces a two-bit command, `chop_cmd`, which the bridge logic applies on top of the requested direction. When current control is not used, the comparator input is tied low and the command stays at drive for every cycle. Dropping the enable holds the period counter and the trip latch in reset, and the command then reads "off". The period and blanking lengths are parameters, for example 1000 and 75 cycles with a 50 MHz clock.

Top module: `chop_ctrl`

## Requirements
- R1: While `en` is low, `chop_cmd` is 2'b00 (off), `period_start` and `blanking` are 0, and `trip` has no effect, whatever its level.
- R2: In the first cycle that `en` is high after being low, `period_start` is 1 and `chop_cmd` is 2'b01 (drive). After that `period_start` pulses for one cycle every PERIOD_CYC cycles, at period offset 0.
- R3: `blanking` is 1 at period offsets 0 to BLANK_CYC-1 and 0 at all other offsets.
- R4: A `trip` that is high only during blanking is not remembered. `chop_cmd` stays 2'b01 for the whole period.
- R5: When `trip` is high at offset k, with BLANK_CYC <= k <= PERIOD_CYC-2, `chop_cmd` becomes 2'b11 (slow decay, both low sides on) from offset k+1 to offset PERIOD_CYC-1, whatever `trip` does afterwards.
- R6: At every period start `chop_cmd` is 2'b01, even if `trip` is still high.
- R7: With `trip` held low, `chop_cmd` is 2'b01 in every enabled cycle.
- R8: A `trip` seen only at offset PERIOD_CYC-1 has no effect. The next period starts in drive and stays in drive.
- R9: Lowering `en` in the middle of a slow-decay interval gives 2'b00 in the same cycle. It also clears the latch, so re-enabling starts a new period in drive.
- R10: With `trip` held high, every period shows exactly BLANK_CYC+1 drive cycles followed by slow decay. This is the minimum on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables chopping; low holds the counters in reset |
| trip | input | 1 | Comparator result, high when sense voltage exceeds the reference |
| chop_cmd | output | 2 | 00 off, 01 drive as requested, 11 slow decay |
| period_start | output | 1 | High in the first cycle of each chopping period |
| blanking | output | 1 | High while the comparator is being ignored |

## Verification
The assertions assume that `trip` is a synchronous, already-qualified level that is stable at each rising edge. They also assume that `en` changes only between edges. The bench drives both inputs one time unit after a rising edge and samples the outputs in the same way. Scenarios place trips before, inside, at the end of and after the blanking window, and at the last offset of a period. The bench also lowers `en` during slow decay, so that the latch clear and the period restart can be seen at the ports.

// File: rtl/chop_pkg.sv
package chop_pkg;
   typedef enum logic [1:0] {
      CHOP_OFF   = 2'b00,
      CHOP_DRIVE = 2'b01,
      CHOP_SLOW  = 2'b11
   } chop_cmd_e;
endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
   parameter int PERIOD_CYC = 1000,
   parameter int BLANK_CYC  = 75
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic period_start,
   output logic blank_win,
   output logic last_cyc
);
   localparam int CNT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST_OFS = CNT_W'(PERIOD_CYC - 1);

   logic [CNT_W-1:0] ofs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ofs_q <= '0;
      else if (!en)            ofs_q <= '0;
      else if (ofs_q == LAST_OFS) ofs_q <= '0;
      else                     ofs_q <= ofs_q + 1'b1;
   end

   assign period_start = en && (ofs_q == '0);
   assign last_cyc     = en && (ofs_q == LAST_OFS);

   generate
      if (BLANK_CYC == 0) begin : g_noblank
         assign blank_win = 1'b0;
      end else begin : g_blank
         localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK_CYC);
         assign blank_win = en && (ofs_q < BLANK_END);
      end
   endgenerate

   // R2
   ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_q <= LAST_OFS);

   // R2
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |=> !period_start);
endmodule

// File: rtl/chop_trip_latch.sv
module chop_trip_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   input  logic arm,
   input  logic trip,
   output logic tripped
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             tripped <= 1'b0;
      else if (!en || clr)    tripped <= 1'b0;
      else if (arm && trip)   tripped <= 1'b1;
   end

   // R9
   clr_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !tripped);
endmodule

// File: rtl/chop_cmd_sel.sv
module chop_cmd_sel
   import chop_pkg::*;
(
   input  logic      en,
   input  logic      tripped,
   output chop_cmd_e cmd
);
   always_comb begin
      if (!en)          cmd = CHOP_OFF;
      else if (tripped) cmd = CHOP_SLOW;
      else              cmd = CHOP_DRIVE;
   end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
   import chop_pkg::*;
#(
   parameter int PERIOD_CYC = 1000,
   parameter int BLANK_CYC  = 75
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       trip,
   output logic [1:0] chop_cmd,
   output logic       period_start,
   output logic       blanking
);
   generate
      if (PERIOD_CYC < 2) begin : g_bad_period
         $error("PERIOD_CYC must be at least 2");
      end
      if (BLANK_CYC < 0 || BLANK_CYC >= PERIOD_CYC - 1) begin : g_bad_blank
         $error("BLANK_CYC must lie in 0 .. PERIOD_CYC-2");
      end
   endgenerate

   logic      last_w;
   logic      tripped_w;
   chop_cmd_e cmd_w;

   chop_period_timer #(
      .PERIOD_CYC(PERIOD_CYC),
      .BLANK_CYC (BLANK_CYC)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .period_start(period_start),
      .blank_win   (blanking),
      .last_cyc    (last_w)
   );

   chop_trip_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .clr    (last_w),
      .arm    (!blanking),
      .trip   (trip),
      .tripped(tripped_w)
   );

   chop_cmd_sel u_sel (
      .en     (en),
      .tripped(tripped_w),
      .cmd    (cmd_w)
   );

   assign chop_cmd = cmd_w;

   // R1
   off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (chop_cmd == 2'b00) && !period_start && !blanking);

   // R6
   drive_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |-> chop_cmd == 2'b01);

   // R4
   no_slow_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blanking |-> chop_cmd != 2'b11);

   // R5
   trip_to_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !blanking && trip && !last_w) ##1 en |-> chop_cmd == 2'b11);

   // R5
   slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chop_cmd == 2'b11) ##1 (en && !period_start) |-> chop_cmd == 2'b11);
endmodule

// File: tb/chop_ctrl_test.sv
module chop_ctrl_test;
   localparam int P = 40;
   localparam int B = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       trip = 1'b0;
   logic [1:0] chop_cmd;
   logic       period_start;
   logic       blanking;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   chop_ctrl #(.PERIOD_CYC(P), .BLANK_CYC(B)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .trip(trip),
      .chop_cmd(chop_cmd), .period_start(period_start), .blanking(blanking)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // leaves the bench at offset 0 of a new period
   task automatic restart();
      en = 1'b0; trip = 1'b0;
      tick();
      en = 1'b1;
      #1;
   endtask

   // one period; trip high at offsets [t_on, t_off)
   task automatic run_period(string req, int t_on, int t_off);
      int first_slow = -1;
      for (int k = 0; k < P; k++)
         if (first_slow < 0 && k >= t_on && k < t_off && k >= B && k <= P - 2)
            first_slow = k + 1;
      for (int k = 0; k < P; k++) begin
         trip = (k >= t_on && k < t_off);
         #1;
         chk(req, "cmd", int'(chop_cmd),
             (first_slow >= 0 && k >= first_slow) ? 3 : 1);
         chk(req, "period_start", int'(period_start), (k == 0) ? 1 : 0);
         chk("R3", "blanking", int'(blanking), (k < B) ? 1 : 0);
         tick();
      end
   endtask

   task automatic t_reset();
      #1;
      chk("R1", "reset cmd", int'(chop_cmd), 0);
      chk("R1", "reset start", int'(period_start), 0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_disabled();
      en = 1'b0;
      for (int k = 0; k < 10; k++) begin
         trip = k[0];
         tick();
         chk("R1", "idle cmd", int'(chop_cmd), 0);
         chk("R1", "idle blanking", int'(blanking), 0);
         chk("R1", "idle start", int'(period_start), 0);
      end
      trip = 1'b0;
   endtask

   task automatic t_quiet();
      restart();
      chk("R2", "start on enable", int'(period_start), 1);
      run_period("R7", P, P);
      run_period("R2", P, P);
   endtask

   task automatic t_blank_trip();
      restart();
      run_period("R4", 1, B);
      run_period("R4", 0, 3);
   endtask

   task automatic t_mid_trip();
      restart();
      run_period("R5", 15, 16);
      run_period("R6", B, B + 1);
      run_period("R5", 20, 30);
   endtask

   task automatic t_held_trip();
      restart();
      run_period("R10", 0, P);
      run_period("R10", 0, P);
      run_period("R6", 0, 1);
   endtask

   task automatic t_last_trip();
      restart();
      run_period("R8", P - 1, P);
      run_period("R8", P, P);
   endtask

   task automatic t_disable_mid();
      restart();
      for (int k = 0; k < 12; k++) begin
         trip = (k == 10);
         tick();
      end
      trip = 1'b0;
      chk("R9", "slow before disable", int'(chop_cmd), 3);
      en = 1'b0;
      #1;
      chk("R9", "off on disable", int'(chop_cmd), 0);
      tick();
      en = 1'b1;
      #1;
      chk("R9", "drive on re-enable", int'(chop_cmd), 1);
      chk("R9", "start on re-enable", int'(period_start), 1);
      run_period("R9", P, P);
   endtask

   initial begin
      t_reset();
      t_disabled();
      t_quiet();
      t_blank_trip();
      t_mid_trip();
      t_held_trip();
      t_last_trip();
      t_disable_mid();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(5 * 100000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule